// File: doc/BRIEF.md
# Virtual Address Translation and Fault Classifier

This block turns a 32-bit virtual address into a physical address for an instruction fetch, a data load or a data store. A fixed set of address-region rules comes first. The upper privileged windows skip translation, and user code touching them takes an address error. Only a small store-queue window is open to user mode. Outside those windows, translation either passes the address through with the top three bits cleared, when translation is disabled, or uses a 64-entry page table cache held inside the block.

A cache lookup resolves to a hit, a miss or a multiple hit. A hit is then checked against the entry's protection and dirty bits. Every failure becomes a 12-bit exception code. On a fault the faulting address is captured, and the page-number field of the page-table-entry-high image is captured too, except on a multiple hit. A 6-bit replace counter advances on every cache lookup, wraps at a software-set boundary, and selects the slot that the next load command fills.

Top module: `addr_xlate_unit`

## Requirements
- R1: With the privileged bit set, an address in 0x80000000..0xBFFFFFFF returns the address ANDed with 0x1FFFFFFF, and an address at or above 0xE0000000 returns unchanged, without any cache lookup.
- R2: With the privileged bit clear, an address in either bypass window outside 0xE0000000..0xE3FFFFFF faults with code 0x100 for a store (req_kind_i=2) and 0x0E0 for a fetch (0) or load (1 or 3); the store-queue window itself translates unchanged.
- R3: With xlate_en_i clear, every non-bypass address returns the address ANDed with 0x1FFFFFFF. Rights rd, wr and ex are all 1 for every R1/R3 success.
- R4: An entry matches only if its valid bit is set and either it is shared, or its ASID equals asid_i, or both sv_i and priv_i are 1.
- R5: The size code maps as 0=1 KiB, 1=4 KiB, 2=64 KiB, 3=1 MiB. The physical address is {ppn,10'b0} with the in-page offset bits cleared, ORed with the virtual offset bits.
- R6: A lookup with no match faults with 0x060 for a store and 0x040 otherwise. Two or more matches fault with 0x140.
- R7: On a single hit the checks run in this order. User mode without protection bit 1 gives 0x0C0 for a store and 0x0A0 otherwise. A store without protection bit 0 gives 0x0C0. A store to a page whose dirty bit is clear gives 0x080.
- R8: On a successful cache translation rd=1, wr = protection bit 0 AND dirty, and ex=1 only for a fetch.
- R9: On any fault, fault_addr_o takes the virtual address and fault_vpn_o takes bits 31:10 of it, except that fault_vpn_o keeps its value on code 0x140. Both keep their values on success.
- R10: urc_o advances by one on every request that reaches the cache. It wraps to 0 when the next value would exceed a nonzero urb_i or would exceed 63. Bypass and pass-through requests leave it unchanged.
- R11: A load command writes the ld_* fields into the entry indexed by urc_o and leaves urc_o unchanged.
- R12: Results appear one cycle after req_i, with rsp_valid_o high for exactly that cycle. rsp_code_o is 0 and rsp_fault_o is 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_vaddr_i | input | 32 | Virtual address |
| priv_i | input | 1 | Privileged mode |
| xlate_en_i | input | 1 | Translation enable |
| sv_i | input | 1 | Single-space mode (ASID ignored when privileged) |
| asid_i | input | 8 | Current address-space id |
| urb_i | input | 6 | Replace counter boundary, 0 = none |
| ld_i | input | 1 | Load-entry command |
| ld_vpn_i | input | 22 | Entry virtual page number |
| ld_asid_i | input | 8 | Entry ASID |
| ld_ppn_i | input | 19 | Entry physical page number |
| ld_sz_i | input | 2 | Entry size code |
| ld_pr_i | input | 2 | Entry protection: bit1 user, bit0 write |
| ld_valid_i | input | 1 | Entry valid |
| ld_shared_i | input | 1 | Entry shared across ASIDs |
| ld_dirty_i | input | 1 | Entry dirty |
| rsp_valid_o | output | 1 | Result valid pulse |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_code_o | output | 12 | Exception code, 0 on success |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_rd_o | output | 1 | Read allowed |
| rsp_wr_o | output | 1 | Write allowed |
| rsp_ex_o | output | 1 | Execute allowed |
| fault_addr_o | output | 32 | Captured faulting address |
| fault_vpn_o | output | 22 | Captured faulting page number |
| urc_o | output | 6 | Replace counter |

## Verification
Each request is driven at a falling edge and sampled at the rising edge that follows. The whole result, the captured fault registers and the replace counter are then read at the next falling edge, one cycle after the strobe. A load command changes only the table at its edge. Its effect is seen through the next request, and urc_o is read right after the load to confirm that the counter did not move. The bench computes every expected value from a model of the table and counter kept beside the stimulus, so each comparison is made in the cycle where the result is due.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned VPN_W  = 22;
  localparam int unsigned PPN_W  = 19;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned CODE_W = 12;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_e;

  typedef struct packed {
    logic              v;
    logic              sh;
    logic              d;
    logic [1:0]        pr;
    logic [1:0]        sz;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_ent_t;

  localparam logic [CODE_W-1:0] EXC_NONE    = 12'h000;
  localparam logic [CODE_W-1:0] EXC_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] EXC_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] EXC_INIT_WR = 12'h080;
  localparam logic [CODE_W-1:0] EXC_VIOL_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] EXC_VIOL_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] EXC_ADDR_RD = 12'h0E0;
  localparam logic [CODE_W-1:0] EXC_ADDR_WR = 12'h100;
  localparam logic [CODE_W-1:0] EXC_MULTI   = 12'h140;

  function automatic logic [31:0] page_off_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_03FF;
      2'd1:    return 32'h0000_0FFF;
      2'd2:    return 32'h0000_FFFF;
      default: return 32'h000F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/xlate_tlb_array.sv
module xlate_tlb_array
  import xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tlb_ent_t          wr_ent_i,
  input  logic [31:0]       lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_use_asid_i,
  output logic              hit_any_o,
  output logic              hit_multi_o,
  output tlb_ent_t          hit_ent_o
);
  tlb_ent_t ent_q [ENTRIES];
  logic [ENTRIES-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (wr_en_i) begin
      ent_q[wr_idx_i] <= wr_ent_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [31:0] off_m;
    logic        asid_ok;
    assign off_m   = page_off_mask(ent_q[g].sz);
    assign asid_ok = ent_q[g].sh || !lk_use_asid_i || (ent_q[g].asid == lk_asid_i);
    assign hit[g]  = ent_q[g].v && asid_ok &&
                     (((lk_va_i ^ {ent_q[g].vpn, 10'b0}) & ~off_m) == 32'b0);
  end

  // OR-select is exact for a single hit; multi-hit result is discarded
  always_comb begin
    hit_any_o   = 1'b0;
    hit_multi_o = 1'b0;
    hit_ent_o   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i]) begin
        hit_multi_o = hit_multi_o | hit_any_o;
        hit_any_o   = 1'b1;
        hit_ent_o   = tlb_ent_t'(hit_ent_o | ent_q[i]);
      end
    end
  end
endmodule

// File: rtl/xlate_urc_counter.sv
module xlate_urc_counter #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [IDX_W-1:0] urb_i,
  output logic [IDX_W-1:0] urc_o
);
  localparam logic [IDX_W:0] TOP = (IDX_W+1)'(ENTRIES - 1);

  logic [IDX_W-1:0] urc_q;
  logic [IDX_W:0]   nxt;
  logic             wrap;

  assign nxt  = {1'b0, urc_q} + 1'b1;
  assign wrap = ((urb_i != '0) && (nxt > {1'b0, urb_i})) || (nxt > TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     urc_q <= '0;
    else if (step_i) urc_q <= wrap ? '0 : nxt[IDX_W-1:0];
  end

  assign urc_o = urc_q;
endmodule

// File: rtl/xlate_classify.sv
module xlate_classify
  import xlate_pkg::*;
(
  input  logic              [31:0] va_i,
  input  acc_e                     kind_i,
  input  logic                     priv_i,
  input  logic                     xlate_en_i,
  input  logic                     hit_any_i,
  input  logic                     hit_multi_i,
  input  tlb_ent_t                 hit_ent_i,
  output logic                     fault_o,
  output logic [CODE_W-1:0]        code_o,
  output logic              [31:0] paddr_o,
  output logic                     rd_o,
  output logic                     wr_o,
  output logic                     ex_o,
  output logic                     tlb_use_o
);
  logic        in_p12, in_p4, in_sq, is_st, is_fe;
  logic [31:0] off_m;

  assign in_p12 = (va_i[31:30] == 2'b10);
  assign in_p4  = (va_i[31:29] == 3'b111);
  assign in_sq  = (va_i[31:26] == 6'b111000);
  assign is_st  = (kind_i == ACC_STORE);
  assign is_fe  = (kind_i == ACC_FETCH);
  assign off_m  = page_off_mask(hit_ent_i.sz);

  always_comb begin
    fault_o   = 1'b0;
    code_o    = EXC_NONE;
    paddr_o   = va_i;
    rd_o      = 1'b1;
    wr_o      = 1'b1;
    ex_o      = 1'b1;
    tlb_use_o = 1'b0;
    if (in_p12 || in_p4) begin
      if (!priv_i && !in_sq) begin
        fault_o = 1'b1;
        code_o  = is_st ? EXC_ADDR_WR : EXC_ADDR_RD;
      end else if (in_p12) begin
        paddr_o = va_i & 32'h1FFF_FFFF;
      end
    end else if (!xlate_en_i) begin
      paddr_o = va_i & 32'h1FFF_FFFF;
    end else begin
      tlb_use_o = 1'b1;
      paddr_o   = ({hit_ent_i.ppn, 10'b0} & ~off_m) | (va_i & off_m);
      wr_o      = hit_ent_i.pr[0] && hit_ent_i.d;
      ex_o      = is_fe;
      fault_o   = 1'b1;
      if (!hit_any_i)                         code_o = is_st ? EXC_MISS_WR : EXC_MISS_RD;
      else if (hit_multi_i)                   code_o = EXC_MULTI;
      else if (!priv_i && !hit_ent_i.pr[1])   code_o = is_st ? EXC_VIOL_WR : EXC_VIOL_RD;
      else if (is_st && !hit_ent_i.pr[0])     code_o = EXC_VIOL_WR;
      else if (is_st && !hit_ent_i.d)         code_o = EXC_INIT_WR;
      else                                    fault_o = 1'b0;
    end
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        req_kind_i,
  input  logic [31:0]       req_vaddr_i,
  input  logic              priv_i,
  input  logic              xlate_en_i,
  input  logic              sv_i,
  input  logic [7:0]        asid_i,
  input  logic [IDX_W-1:0]  urb_i,
  input  logic              ld_i,
  input  logic [21:0]       ld_vpn_i,
  input  logic [7:0]        ld_asid_i,
  input  logic [18:0]       ld_ppn_i,
  input  logic [1:0]        ld_sz_i,
  input  logic [1:0]        ld_pr_i,
  input  logic              ld_valid_i,
  input  logic              ld_shared_i,
  input  logic              ld_dirty_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [11:0]       rsp_code_o,
  output logic [31:0]       rsp_paddr_o,
  output logic              rsp_rd_o,
  output logic              rsp_wr_o,
  output logic              rsp_ex_o,
  output logic [31:0]       fault_addr_o,
  output logic [21:0]       fault_vpn_o,
  output logic [IDX_W-1:0]  urc_o
);
  tlb_ent_t          ld_ent, hit_ent;
  logic              hit_any, hit_multi, use_asid;
  logic              c_fault, c_rd, c_wr, c_ex, c_tlb;
  logic [CODE_W-1:0] c_code;
  logic [31:0]       c_paddr;
  logic [IDX_W-1:0]  urc;

  assign use_asid = !(sv_i && priv_i);
  assign ld_ent   = '{v: ld_valid_i, sh: ld_shared_i, d: ld_dirty_i, pr: ld_pr_i,
                      sz: ld_sz_i, asid: ld_asid_i, vpn: ld_vpn_i, ppn: ld_ppn_i};

  xlate_tlb_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tlb (
    .clk_i, .rst_ni,
    .wr_en_i(ld_i), .wr_idx_i(urc), .wr_ent_i(ld_ent),
    .lk_va_i(req_vaddr_i), .lk_asid_i(asid_i), .lk_use_asid_i(use_asid),
    .hit_any_o(hit_any), .hit_multi_o(hit_multi), .hit_ent_o(hit_ent)
  );

  xlate_classify u_cls (
    .va_i(req_vaddr_i), .kind_i(acc_e'(req_kind_i)), .priv_i, .xlate_en_i,
    .hit_any_i(hit_any), .hit_multi_i(hit_multi), .hit_ent_i(hit_ent),
    .fault_o(c_fault), .code_o(c_code), .paddr_o(c_paddr),
    .rd_o(c_rd), .wr_o(c_wr), .ex_o(c_ex), .tlb_use_o(c_tlb)
  );

  xlate_urc_counter #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_urc (
    .clk_i, .rst_ni, .step_i(req_i && c_tlb), .urb_i, .urc_o(urc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_fault_o  <= 1'b0;
      rsp_code_o   <= '0;
      rsp_paddr_o  <= '0;
      rsp_rd_o     <= 1'b0;
      rsp_wr_o     <= 1'b0;
      rsp_ex_o     <= 1'b0;
      fault_addr_o <= '0;
      fault_vpn_o  <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_fault_o <= c_fault;
        rsp_code_o  <= c_code;
        rsp_paddr_o <= c_paddr;
        rsp_rd_o    <= c_rd;
        rsp_wr_o    <= c_wr;
        rsp_ex_o    <= c_ex;
        if (c_fault) begin
          fault_addr_o <= req_vaddr_i;
          if (c_code != EXC_MULTI) fault_vpn_o <= req_vaddr_i[31:10];
        end
      end
    end
  end

  assign urc_o = urc;
endmodule

// File: rtl/addr_xlate_unit_chk.sv
module addr_xlate_unit_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             rsp_valid_o,
  input logic             rsp_fault_o,
  input logic [11:0]      rsp_code_o,
  input logic [31:0]      fault_addr_o,
  input logic [21:0]      fault_vpn_o,
  input logic [IDX_W-1:0] urc_o
);
  a_r12_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r12_no_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  a_r12_ok_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_code_o == 12'h000));
  a_r9_vpn_matches_tea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && rsp_code_o != 12'h140) |-> (fault_vpn_o == fault_addr_o[31:10]));
  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(fault_addr_o) && $stable(fault_vpn_o)));
  a_r11_urc_still_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(urc_o));
endmodule

bind addr_xlate_unit addr_xlate_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .rsp_valid_o, .rsp_fault_o, .rsp_code_o,
  .fault_addr_o, .fault_vpn_o, .urc_o
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
  import xlate_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_i = 0;
  logic [1:0]  kind_i = 0;
  logic [31:0] va_i = 0;
  logic        priv = 1, at = 1, sv = 0;
  logic [7:0]  asid = 8'd1;
  logic [5:0]  urb = 0;
  logic        ld_i = 0;
  logic [21:0] l_vpn = 0;
  logic [7:0]  l_asid = 0;
  logic [18:0] l_ppn = 0;
  logic [1:0]  l_sz = 0, l_pr = 0;
  logic        l_v = 0, l_sh = 0, l_d = 0;

  logic        rsp_valid, rsp_fault, rsp_rd, rsp_wr, rsp_ex;
  logic [11:0] rsp_code;
  logic [31:0] rsp_paddr, tea;
  logic [21:0] fvpn;
  logic [5:0]  urc;

  addr_xlate_unit u_dut (
    .clk_i(clk), .rst_ni, .req_i, .req_kind_i(kind_i), .req_vaddr_i(va_i),
    .priv_i(priv), .xlate_en_i(at), .sv_i(sv), .asid_i(asid), .urb_i(urb),
    .ld_i, .ld_vpn_i(l_vpn), .ld_asid_i(l_asid), .ld_ppn_i(l_ppn), .ld_sz_i(l_sz),
    .ld_pr_i(l_pr), .ld_valid_i(l_v), .ld_shared_i(l_sh), .ld_dirty_i(l_d),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_code_o(rsp_code),
    .rsp_paddr_o(rsp_paddr), .rsp_rd_o(rsp_rd), .rsp_wr_o(rsp_wr), .rsp_ex_o(rsp_ex),
    .fault_addr_o(tea), .fault_vpn_o(fvpn), .urc_o(urc)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  tlb_ent_t    m_ent [64];
  int          m_urc = 0;
  logic [31:0] m_tea = 0;
  logic [21:0] m_vpn = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic longint pg_bytes(input logic [1:0] sz);
    case (sz)
      2'd0: return 1024;
      2'd1: return 4096;
      2'd2: return 65536;
      default: return 1048576;
    endcase
  endfunction

  function automatic void model(input int kind, input logic [31:0] va,
                                output logic [11:0] code, output logic [31:0] pa,
                                output logic rd, output logic wr, output logic ex,
                                output logic tlb);
    int nhit = 0; int hi = 0;
    bit st = (kind == 2);
    code = 0; pa = va; rd = 1; wr = 1; ex = 1; tlb = 0;
    if ((va >= 32'h8000_0000 && va < 32'hC000_0000) || va >= 32'hE000_0000) begin
      if (!priv && !(va >= 32'hE000_0000 && va < 32'hE400_0000)) code = st ? 12'h100 : 12'h0E0;
      else if (va < 32'hC000_0000) pa = va - 32'h8000_0000 - ((va >= 32'hA000_0000) ? 32'h2000_0000 : 0);
    end else if (!at) begin
      pa = {3'b000, va[28:0]};
    end else begin
      tlb = 1;
      for (int i = 0; i < 64; i++) begin
        longint sz = pg_bytes(m_ent[i].sz);
        longint base = (longint'(m_ent[i].vpn) * 1024) / sz * sz;
        if (m_ent[i].v && (m_ent[i].sh || (sv && priv) || m_ent[i].asid == asid) &&
            longint'(va) >= base && longint'(va) < base + sz) begin
          nhit++; hi = i;
        end
      end
      if (nhit == 0) code = st ? 12'h060 : 12'h040;
      else if (nhit > 1) code = 12'h140;
      else begin
        longint sz = pg_bytes(m_ent[hi].sz);
        longint pb = (longint'(m_ent[hi].ppn) * 1024) / sz * sz;
        if (!priv && !m_ent[hi].pr[1]) code = st ? 12'h0C0 : 12'h0A0;
        else if (st && !m_ent[hi].pr[0]) code = 12'h0C0;
        else if (st && !m_ent[hi].d) code = 12'h080;
        pa = 32'(pb + (longint'(va) % sz));
        wr = m_ent[hi].pr[0] & m_ent[hi].d;
        ex = (kind == 0);
      end
    end
  endfunction

  function automatic string tag_of(input logic [11:0] c, input logic tlb);
    if (c == 12'h0E0 || c == 12'h100) return "R2";
    if (c == 12'h040 || c == 12'h060 || c == 12'h140) return "R6";
    if (c != 0) return "R7";
    return tlb ? "R5" : "R1/R3";
  endfunction

  task automatic xlate(input int kind, input logic [31:0] va);
    logic [11:0] ec; logic [31:0] ep; logic erd, ewr, eex, etl;
    string t;
    model(kind, va, ec, ep, erd, ewr, eex, etl);
    t = tag_of(ec, etl);
    req_i = 1; kind_i = 2'(kind); va_i = va;
    @(negedge clk);
    req_i = 0;
    if (etl) begin
      int n = m_urc + 1;
      if ((urb != 0 && n > urb) || n > 63) n = 0;
      m_urc = n;
    end
    if (ec != 0) begin
      m_tea = va;
      if (ec != 12'h140) m_vpn = va[31:10];
    end
    chk("R12 valid", 32'(rsp_valid), 1);
    chk({t, " code"}, 32'(rsp_code), 32'(ec));
    chk("R12 fault flag", 32'(rsp_fault), 32'(ec != 0));
    if (ec == 0) begin
      chk({t, " paddr"}, rsp_paddr, ep);
      chk("R8 rights", {29'b0, rsp_rd, rsp_wr, rsp_ex}, {29'b0, erd, ewr, eex});
    end
    chk("R9 tea", tea, m_tea);
    chk("R9 vpn", 32'(fvpn), 32'(m_vpn));
    chk("R10 urc", 32'(urc), 32'(m_urc));
  endtask

  task automatic load(input logic [21:0] vpn, input logic [7:0] a, input logic [18:0] ppn,
                      input logic [1:0] sz, input logic [1:0] pr,
                      input logic v, input logic sh, input logic d);
    m_ent[m_urc] = '{v: v, sh: sh, d: d, pr: pr, sz: sz, asid: a, vpn: vpn, ppn: ppn};
    l_vpn = vpn; l_asid = a; l_ppn = ppn; l_sz = sz; l_pr = pr; l_v = v; l_sh = sh; l_d = d;
    ld_i = 1;
    @(negedge clk);
    ld_i = 0;
    chk("R11 urc unchanged by load", 32'(urc), 32'(m_urc));
  endtask

  // miss lookup to step the replace counter
  task automatic bump();
    xlate(1, 32'h7FF0_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) m_ent[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 reset valid", 32'(rsp_valid), 0);
    chk("R10 reset urc", 32'(urc), 0);
    chk("R9 reset tea", tea, 0);
    rst_ni = 1;
    @(negedge clk);

    // R1 privileged bypass
    xlate(0, 32'h8123_4567);
    chk("R1 P1 literal", rsp_paddr, 32'h0123_4567);
    xlate(1, 32'hFF00_0010);
    xlate(2, 32'hB000_0004);
    // R2 user address errors and store-queue window
    priv = 0;
    xlate(1, 32'hA000_0000);
    xlate(2, 32'h9000_0000);
    chk("R2 store literal", 32'(rsp_code), 32'h100);
    xlate(2, 32'hE000_0040);
    xlate(0, 32'hE400_0000);
    xlate(3, 32'hE3FF_FFFC);
    priv = 1;
    // R3 translation off
    at = 0;
    xlate(1, 32'h4321_0000);
    chk("R3 literal", rsp_paddr, 32'h0321_0000);
    at = 1;

    // R11 R5: entries at successive replace slots
    load(22'(32'h0040_0000 >> 10), 8'd1, 19'h00123, 2'd1, 2'b11, 1, 0, 1);
    xlate(1, 32'h0040_0ABC);
    chk("R5 literal 4K", rsp_paddr, 32'h0004_8ABC);
    xlate(2, 32'h0040_0F00);
    load(22'(32'h0050_0000 >> 10), 8'd1, 19'h00200, 2'd2, 2'b10, 1, 0, 0);
    xlate(2, 32'h0050_1234);
    bump();
    load(22'(32'h0060_0000 >> 10), 8'd1, 19'h00300, 2'd0, 2'b11, 1, 0, 0);
    xlate(2, 32'h0060_0010);
    chk("R7 initial write literal", 32'(rsp_code), 32'h080);
    bump();
    load(22'(32'h0070_0000 >> 10), 8'd1, 19'h7FC00, 2'd3, 2'b01, 1, 0, 1);
    priv = 0;
    xlate(1, 32'h0070_5555);
    xlate(2, 32'h0070_5555);
    xlate(0, 32'h0070_5555);
    priv = 1;
    xlate(0, 32'h0075_5555);
    // R6 multi-hit via a shared entry over the first page
    bump();
    load(22'(32'h0040_0000 >> 10), 8'd9, 19'h00001, 2'd0, 2'b11, 1, 1, 1);
    xlate(1, 32'h0040_0004);
    chk("R6 multi literal", 32'(rsp_code), 32'h140);
    xlate(2, 32'h0000_0000);
    // R4 ASID rules
    asid = 8'd2;
    xlate(1, 32'h0050_0010);
    sv = 1;
    xlate(1, 32'h0050_0010);
    priv = 0;
    xlate(1, 32'h0050_0010);
    priv = 1; sv = 0; asid = 8'd1;
    bump();
    load(22'(32'h0030_0000 >> 10), 8'd1, 19'h00005, 2'd1, 2'b11, 0, 1, 1);
    xlate(1, 32'h0030_0000);
    // R10 wrap at boundary
    urb = 6'd3;
    for (int k = 0; k < 6; k++) bump();
    urb = 6'd0;
    // R12 pulse ends
    @(negedge clk);
    chk("R12 valid drops", 32'(rsp_valid), 0);

    // constrained random
    for (int it = 0; it < 1500; it++) begin
      int r = $urandom % 10;
      if (r < 2) begin
        logic [31:0] b = ($urandom % 8) << 20;
        load(22'((b >> 10) | ($urandom % 1024)), 8'($urandom % 3), 19'($urandom),
             2'($urandom), 2'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 4 == 0),
             1'($urandom));
      end else begin
        logic [31:0] va;
        if (r == 9) begin
          priv = 1'($urandom); at = 1'($urandom % 5 != 0); sv = 1'($urandom);
          asid = 8'($urandom % 3);
          urb = ($urandom % 3 == 0) ? 6'($urandom % 40) : 6'd0;
        end
        if ($urandom % 2) va = (($urandom % 8) << 20) | ($urandom % 32'h0010_0000);
        else va = $urandom;
        xlate(int'($urandom % 4), va);
      end
    end
    finish_run();
  end
endmodule